// File: doc/BRIEF.md
# Cache Line Fill and Routing Controller

This controller sits between a processor cache and external memory and handles one cache miss at a time. On each miss it picks a path. A cacheable address normally goes to a dedicated point-to-point cache link. An uncacheable address goes to the general system bus. A cacheable address also goes to the system bus when the cache is disabled by software and the build parameter does not force link use.

On the link path, the block writes one request word into an outgoing FIFO-style channel. It then pops the returned line words, one per cycle, from an incoming FIFO-style channel. Each popped word is written into the cache data array in the same cycle.

The line can be filled in one of two orders. In critical-word-first order, the requested word comes first and the index then wraps around the line. In linear order, the words come from the line start upward. The processor stall is released as soon as the requested word lands in the array, and the rest of the line fills in the background. On the system-bus path, the block presents the miss address and holds its request until the bus reports completion.

Top module: `line_fill_router`

## Requirements
- R1: After reset the block is idle: `missReady`=1, `stall`=0, and `reqWrite`, `rspRead`, `arrWrite`, `busReq` and `fillDone` are all 0.
- R2: A miss with an address inside [CACHE_BASE, CACHE_HIGH] goes to the link when ALWAYS_LINK=1 or `cacheEn`=1. With ALWAYS_LINK=0 and `cacheEn`=0, it goes to the system bus. Link and bus activity never overlap.
- R3: A miss with an address outside [CACHE_BASE, CACHE_HIGH] always goes to the system bus, whatever `cacheEn` is.
- R4: A link request is written for exactly one cycle, and only in a cycle where `reqFull`=0. In critical-word-first mode (`critFirst`=1) `reqAddr` is the miss address with bits [1:0] cleared. In linear mode it is the miss address with its low log2(LINE_WORDS)+2 bits cleared.
- R5: `rspRead` is high only while a fill is in progress and `rspExists`=1. There is one pop per line word, LINE_WORDS pops in total.
- R6: In every pop cycle `arrWrite`=1 and `arrData` equals `rspData`. Outside pop cycles `arrWrite`=0.
- R7: In critical-word-first mode, pop k (k counted from 0) gives `arrIndex` = (s + k) mod LINE_WORDS, where s is miss address bits [2 +: log2(LINE_WORDS)].
- R8: In linear mode, pop k gives `arrIndex` = k.
- R9: `stall` is 1 from the cycle after a miss is accepted. It drops in the pop cycle whose `arrIndex` equals s, or in the cycle `busDone`=1 on the bus path, and stays 0 until the next miss.
- R10: `missReady` is 0 from acceptance until the line has been consumed or the bus transfer has completed. A `missValid` raised in that time is ignored.
- R11: `fillDone` is 1 for exactly the one cycle after the last word's pop. In that same cycle `missReady` is 1 again.
- R12: On the bus path, `busReq` is 1 with `busAddr` equal to the miss address. It stays high until a cycle with `busDone`=1, and the block is idle in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | Cache miss present |
| missAddr | input | ADDR_W | Byte address of the missing word |
| cacheEn | input | 1 | Software cache-enable bit |
| critFirst | input | 1 | 1: critical-word-first order, 0: linear order |
| missReady | output | 1 | Idle and accepting a miss |
| stall | output | 1 | Processor stall |
| reqWrite | output | 1 | Write strobe of the link request channel |
| reqAddr | output | ADDR_W | Link request address |
| reqFull | input | 1 | Link request channel full |
| rspRead | output | 1 | Pop strobe of the link return channel |
| rspExists | input | 1 | Link return channel holds a word |
| rspData | input | 32 | Link return word |
| arrWrite | output | 1 | Cache data-array write enable |
| arrIndex | output | log2(LINE_WORDS) | Word index within the line |
| arrData | output | 32 | Data-array write data |
| fillDone | output | 1 | One-cycle pulse after the last line word |
| busReq | output | 1 | System bus request |
| busAddr | output | ADDR_W | System bus address |
| busDone | input | 1 | System bus transfer complete |

## Verification
A miss is accepted on the edge where `missValid` meets `missReady`. The route becomes visible one cycle later, as either `reqWrite` (while `reqFull`=0) or `busReq`. `rspRead`, `arrWrite`, `arrIndex`, `arrData` and the stall release all follow in the same cycle as `rspExists` or `busDone`. `fillDone` comes one cycle after the last pop. The bench drives its inputs on the falling edge, waits a short settle delay and samples within that same half period, so each combinational result is checked in the cycle its stimulus is applied and each registered result one edge later. The bench keeps its own model of the expected index, the stall state and the route, and compares the outputs against that model.

// File: rtl/lfr_pkg.sv
package lfr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_FILL = 2'd2,
    ST_BUS  = 2'd3
  } lfr_state_e;

  typedef struct packed {
    logic capture;
    logic pop;
  } lfr_strobe_t;
endpackage

// File: rtl/lfr_datapath.sv
module lfr_datapath
  import lfr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned LINE_WORDS  = 4,
  parameter logic [ADDR_W-1:0] CACHE_BASE = 32'h1000_0000,
  parameter logic [ADDR_W-1:0] CACHE_HIGH = 32'h1FFF_FFFF,
  parameter bit ALWAYS_LINK = 1'b0,
  localparam int unsigned IDX_W = $clog2(LINE_WORDS),
  localparam int unsigned OFF_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  lfr_strobe_t       strobe,
  input  logic [ADDR_W-1:0] missAddr,
  input  logic              cacheEn,
  input  logic              critFirst,
  output logic              goLink,
  output logic              lastWord,
  output logic              critHit,
  output logic              critSeen,
  output logic [IDX_W-1:0]  wordIdx,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [ADDR_W-1:0] heldAddr
);
  logic [ADDR_W-1:0] addrQ;
  logic [IDX_W-1:0]  startQ;
  logic [IDX_W-1:0]  cntQ;
  logic              critQ;
  logic              seenQ;
  logic              inRange;
  logic              linkGate;

  assign inRange = (missAddr >= CACHE_BASE) && (missAddr <= CACHE_HIGH);

  generate
    if (ALWAYS_LINK) begin : g_always
      assign linkGate = 1'b1;
    end else begin : g_gated
      assign linkGate = cacheEn;
    end
  endgenerate

  assign goLink = inRange && linkGate;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      startQ <= '0;
      cntQ   <= '0;
      critQ  <= 1'b0;
      seenQ  <= 1'b0;
    end else if (strobe.capture) begin
      addrQ  <= missAddr;
      startQ <= missAddr[2 +: IDX_W];
      cntQ   <= '0;
      critQ  <= critFirst;
      seenQ  <= 1'b0;
    end else if (strobe.pop) begin
      cntQ <= cntQ + 1'b1;
      if (critHit) seenQ <= 1'b1;
    end
  end

  // Index wraps naturally: LINE_WORDS is a power of two.
  assign wordIdx  = critQ ? (startQ + cntQ) : cntQ;
  assign lastWord = (cntQ == IDX_W'(LINE_WORDS - 1));
  assign critHit  = (wordIdx == startQ);
  assign critSeen = seenQ;
  assign heldAddr = addrQ;
  assign reqAddr  = critQ ? {addrQ[ADDR_W-1:2], 2'b00}
                          : {addrQ[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
endmodule

// File: rtl/lfr_ctrl.sv
module lfr_ctrl
  import lfr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        missValid,
  input  logic        goLink,
  input  logic        reqFull,
  input  logic        rspExists,
  input  logic        busDone,
  input  logic        lastWord,
  input  logic        critHit,
  input  logic        critSeen,
  output lfr_strobe_t strobe,
  output logic        missReady,
  output logic        reqWrite,
  output logic        rspRead,
  output logic        busReq,
  output logic        stall,
  output logic        fillDone
);
  lfr_state_e stateQ, stateD;
  logic       doneQ;

  always_comb begin
    stateD         = stateQ;
    strobe.capture = 1'b0;
    strobe.pop     = 1'b0;
    missReady      = 1'b0;
    reqWrite       = 1'b0;
    busReq         = 1'b0;
    stall          = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        missReady = 1'b1;
        if (missValid) begin
          strobe.capture = 1'b1;
          stateD = goLink ? ST_REQ : ST_BUS;
        end
      end
      ST_REQ: begin
        stall    = 1'b1;
        reqWrite = !reqFull;
        if (!reqFull) stateD = ST_FILL;
      end
      ST_FILL: begin
        strobe.pop = rspExists;
        stall = !critSeen && !(rspExists && critHit);
        if (rspExists && lastWord) stateD = ST_IDLE;
      end
      ST_BUS: begin
        busReq = 1'b1;
        stall  = !busDone;
        if (busDone) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign rspRead  = strobe.pop;
  assign fillDone = doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= strobe.pop && lastWord;
    end
  end
endmodule

// File: rtl/line_fill_router.sv
module line_fill_router
  import lfr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned LINE_WORDS  = 4,
  parameter logic [ADDR_W-1:0] CACHE_BASE = 32'h1000_0000,
  parameter logic [ADDR_W-1:0] CACHE_HIGH = 32'h1FFF_FFFF,
  parameter bit ALWAYS_LINK = 1'b0,
  localparam int unsigned IDX_W = $clog2(LINE_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              missValid,
  input  logic [ADDR_W-1:0] missAddr,
  input  logic              cacheEn,
  input  logic              critFirst,
  output logic              missReady,
  output logic              stall,
  output logic              reqWrite,
  output logic [ADDR_W-1:0] reqAddr,
  input  logic              reqFull,
  output logic              rspRead,
  input  logic              rspExists,
  input  logic [31:0]       rspData,
  output logic              arrWrite,
  output logic [IDX_W-1:0]  arrIndex,
  output logic [31:0]       arrData,
  output logic              fillDone,
  output logic              busReq,
  output logic [ADDR_W-1:0] busAddr,
  input  logic              busDone
);
  lfr_strobe_t strobe;
  logic goLink, lastWord, critHit, critSeen;

  lfr_datapath #(
    .ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS), .CACHE_BASE(CACHE_BASE),
    .CACHE_HIGH(CACHE_HIGH), .ALWAYS_LINK(ALWAYS_LINK)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .missAddr(missAddr),
    .cacheEn(cacheEn), .critFirst(critFirst), .goLink(goLink),
    .lastWord(lastWord), .critHit(critHit), .critSeen(critSeen),
    .wordIdx(arrIndex), .reqAddr(reqAddr), .heldAddr(busAddr)
  );

  lfr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .missValid(missValid), .goLink(goLink),
    .reqFull(reqFull), .rspExists(rspExists), .busDone(busDone),
    .lastWord(lastWord), .critHit(critHit), .critSeen(critSeen),
    .strobe(strobe), .missReady(missReady), .reqWrite(reqWrite),
    .rspRead(rspRead), .busReq(busReq), .stall(stall), .fillDone(fillDone)
  );

  assign arrWrite = strobe.pop;
  assign arrData  = rspData;
endmodule

// File: rtl/lfr_checker.sv
module lfr_checker (
  input logic clk,
  input logic rstN,
  input logic missReady,
  input logic stall,
  input logic reqWrite,
  input logic reqFull,
  input logic rspRead,
  input logic rspExists,
  input logic arrWrite,
  input logic fillDone,
  input logic busReq,
  input logic busDone
);
  // R4
  req_not_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqWrite |-> !reqFull);
  // R4
  req_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqWrite |=> !reqWrite);
  // R5
  pop_needs_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspRead |-> rspExists);
  // R6
  write_on_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    arrWrite |-> rspRead);
  // R11
  done_after_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillDone |-> $past(rspRead));
  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillDone |=> !fillDone);
  // R9
  idle_no_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    missReady |-> !stall);
  // R12
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busDone) |=> busReq);
  // R2
  path_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> !(reqWrite || rspRead));
endmodule

bind line_fill_router lfr_checker u_lfr_checker (
  .clk(clk), .rstN(rstN), .missReady(missReady), .stall(stall),
  .reqWrite(reqWrite), .reqFull(reqFull), .rspRead(rspRead),
  .rspExists(rspExists), .arrWrite(arrWrite), .fillDone(fillDone),
  .busReq(busReq), .busDone(busDone)
);

// File: tb/line_fill_router_bench.sv
module line_fill_router_bench;
  localparam int L = 8;
  localparam int L2 = 4;
  localparam logic [31:0] BASE = 32'h1000_0000;
  localparam logic [31:0] HIGH = 32'h1FFF_FFFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic missValid = 0, cacheEn = 0, critFirst = 0, reqFull = 0, rspExists = 0, busDone = 0;
  logic [31:0] missAddr = '0, rspData = '0;
  logic missReady, stall, reqWrite, rspRead, arrWrite, fillDone, busReq;
  logic [31:0] reqAddr, arrData, busAddr;
  logic [2:0] arrIndex;

  line_fill_router #(.LINE_WORDS(L), .ALWAYS_LINK(1'b0)) u_line_fill_router (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missAddr(missAddr),
    .cacheEn(cacheEn), .critFirst(critFirst), .missReady(missReady),
    .stall(stall), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqFull(reqFull),
    .rspRead(rspRead), .rspExists(rspExists), .rspData(rspData),
    .arrWrite(arrWrite), .arrIndex(arrIndex), .arrData(arrData),
    .fillDone(fillDone), .busReq(busReq), .busAddr(busAddr), .busDone(busDone)
  );

  logic mValid2 = 0, en2 = 0;
  logic [31:0] mAddr2 = '0;
  logic ready2, stall2, reqW2, rd2, aw2, done2, busReq2;
  logic [31:0] reqA2, aData2, busA2;
  logic [1:0] aIdx2;

  line_fill_router #(.LINE_WORDS(L2), .ALWAYS_LINK(1'b1)) u_line_fill_router_always (
    .clk(clk), .rstN(rstN), .missValid(mValid2), .missAddr(mAddr2),
    .cacheEn(en2), .critFirst(1'b1), .missReady(ready2), .stall(stall2),
    .reqWrite(reqW2), .reqAddr(reqA2), .reqFull(1'b0), .rspRead(rd2),
    .rspExists(1'b1), .rspData(32'h5A5A_0001), .arrWrite(aw2), .arrIndex(aIdx2),
    .arrData(aData2), .fillDone(done2), .busReq(busReq2), .busAddr(busA2),
    .busDone(1'b1)
  );

  int nChecks = 0;
  int nFail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit inRange(input logic [31:0] a);
    return (a >= BASE) && (a <= HIGH);
  endfunction

  task automatic runMiss(input logic [31:0] a, input bit en, input bit crit);
    bit link, seen;
    int start, idx;
    logic [31:0] expReq;
    link = inRange(a) && en;
    start = int'(a[4:2]);
    seen = 0;
    @(negedge clk);
    #1 chk(missReady == 1'b1, "R10 ready before miss", {31'd0, missReady}, 32'd1);
    missValid = 1; missAddr = a; cacheEn = en; critFirst = crit;
    @(negedge clk);
    missValid = 0; missAddr = $urandom;
    #1;
    if (link) begin
      chk(busReq == 1'b0, "R2 link chosen, no bus", {31'd0, busReq}, 32'd0);
      repeat ($urandom % 3) begin
        reqFull = 1; #1;
        chk(reqWrite == 1'b0, "R4 no write when full", {31'd0, reqWrite}, 32'd0);
        chk(stall == 1'b1, "R9 stall during request", {31'd0, stall}, 32'd1);
        @(negedge clk);
      end
      reqFull = 0; #1;
      expReq = crit ? {a[31:2], 2'b00} : {a[31:5], 5'd0};
      chk(reqWrite == 1'b1, "R4 request written", {31'd0, reqWrite}, 32'd1);
      chk(reqAddr == expReq, "R4 request address", reqAddr, expReq);
      chk(missReady == 1'b0, "R10 busy during request", {31'd0, missReady}, 32'd0);
      @(negedge clk);
      for (int k = 0; k < L; k++) begin
        repeat ($urandom % 3) begin
          rspExists = 0; missValid = 1; #1;
          chk(rspRead == 1'b0 && arrWrite == 1'b0, "R5 no pop without data", {31'd0, rspRead}, 32'd0);
          chk(missReady == 1'b0, "R10 miss ignored while filling", {31'd0, missReady}, 32'd0);
          chk(stall == !seen, "R9 stall between words", {31'd0, stall}, {31'd0, !seen});
          @(negedge clk);
          missValid = 0;
        end
        rspExists = 1; rspData = $urandom; #1;
        idx = crit ? (start + k) % L : k;
        if (idx == start) seen = 1;
        chk(rspRead == 1'b1, "R5 pop with data", {31'd0, rspRead}, 32'd1);
        chk(arrWrite == 1'b1 && arrData == rspData, "R6 array write", arrData, rspData);
        chk(int'(arrIndex) == idx, crit ? "R7 critical-first index" : "R8 linear index", {29'd0, arrIndex}, idx);
        chk(stall == !seen, "R9 stall on pop", {31'd0, stall}, {31'd0, !seen});
        chk(fillDone == 1'b0, "R11 no early done", {31'd0, fillDone}, 32'd0);
        @(negedge clk);
      end
      rspExists = 0; #1;
      chk(fillDone == 1'b1, "R11 done pulse", {31'd0, fillDone}, 32'd1);
      chk(missReady == 1'b1 && stall == 1'b0, "R11 idle with done", {31'd0, missReady}, 32'd1);
      chk(busReq == 1'b0 && reqWrite == 1'b0, "R10 ignored miss left no activity", {31'd0, busReq}, 32'd0);
      @(negedge clk); #1;
      chk(fillDone == 1'b0, "R11 done single cycle", {31'd0, fillDone}, 32'd0);
    end else begin
      chk(reqWrite == 1'b0, inRange(a) ? "R2 disabled cache to bus" : "R3 uncacheable to bus", {31'd0, reqWrite}, 32'd0);
      chk(busReq == 1'b1 && busAddr == a, "R12 bus request address", busAddr, a);
      repeat ($urandom % 4) begin
        busDone = 0; #1;
        chk(busReq == 1'b1 && stall == 1'b1, "R12 bus held", {31'd0, busReq}, 32'd1);
        @(negedge clk);
      end
      busDone = 1; #1;
      chk(stall == 1'b0, "R9 stall released on bus done", {31'd0, stall}, 32'd0);
      @(negedge clk);
      busDone = 0; #1;
      chk(busReq == 1'b0 && missReady == 1'b1, "R12 idle after bus done", {31'd0, busReq}, 32'd0);
    end
  endtask

  task automatic runAlways(input logic [31:0] a, input bit en);
    @(negedge clk);
    mValid2 = 1; mAddr2 = a; en2 = en;
    @(negedge clk);
    mValid2 = 0; #1;
    chk(reqW2 == inRange(a), "R2 always-link route", {31'd0, reqW2}, {31'd0, inRange(a)});
    chk(busReq2 == !inRange(a), "R3 always-link bus route", {31'd0, busReq2}, {31'd0, !inRange(a)});
    repeat (L2 + 3) @(negedge clk);
    #1 chk(ready2 == 1'b1, "R10 always-link back idle", {31'd0, ready2}, 32'd1);
  endtask

  function automatic logic [31:0] randIn();
    return BASE | ($urandom & 32'h0FFF_FFFC);
  endfunction

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    #1;
    chk(missReady == 1'b1 && stall == 1'b0, "R1 reset idle", {31'd0, missReady}, 32'd1);
    chk({reqWrite, rspRead, arrWrite, busReq, fillDone} == 5'd0, "R1 reset strobes", {27'd0, reqWrite, rspRead, arrWrite, busReq, fillDone}, 32'd0);
    rstN = 1;
    // Directed corners: range edges, start at last word, start at word 0.
    runMiss(BASE, 1, 1);
    runMiss(HIGH & 32'hFFFF_FFFC, 1, 1);
    runMiss(BASE | 32'h1C, 1, 1);
    runMiss(BASE | 32'h1C, 1, 0);
    runMiss(BASE - 4, 1, 1);
    runMiss(HIGH + 1, 1, 0);
    runMiss(BASE | 32'h8, 0, 1);
    for (int i = 0; i < 40; i++) begin
      logic [31:0] a;
      a = ($urandom % 3 == 0) ? ($urandom | 32'h2000_0000) : randIn();
      runMiss(a, 1'($urandom), 1'($urandom));
    end
    runAlways(BASE | 32'hC, 0);
    runAlways(BASE | 32'h4, 1);
    runAlways(HIGH + 1, 1);
    runAlways(BASE - 4, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule